// File: doc/BRIEF.md
# Eight-bit OR-merged ALU datapath

This block is the purely combinational arithmetic and logic slice of a small eight-bit core. It takes two operands, a source operand and a second operand, and produces one result byte, a carry out and a zero flag. It holds no registers and does no opcode decoding. An external decoder drives a set of enable and steering lines, and every operation is selected by the pattern on those lines.

Four result sources exist: a boolean unit, a carry-lookahead adder, an external input byte and a next-program-counter byte. Each source is gated to zero by its own enable, and the gated values are merged by a bitwise OR instead of a wide multiplexer. A single invert line complements the second operand before it reaches both the boolean unit and the adder, and it also serves as the adder's carry-in. This gives subtraction and AND-with-complement from the same hardware as addition and AND. A pass line forces the source operand to zero inside the boolean unit, so the OR gate hands the second operand through unchanged. When every source enable is low, the result is zero, and this acts as the clear operation.

Top module: `alu8_rop_datapath`

## Requirements
- R1: With `rop_en` and `or_sel` high and all other steering low, `result` equals `sri | snd`.
- R2: With `rop_en` and `xor_sel` high, `result` equals `sri ^ snd`.
- R3: With `rop_en` and `and_sel` high, `result` equals `sri & snd`.
- R4: With `rop_en`, `and_sel` and `neg_snd` high, `result` equals `sri & ~snd`.
- R5: With `rop_en`, `or_sel` and `pass_snd` high, `result` equals `snd`, whatever `sri` holds.
- R6: With `cla_en` high and `neg_snd` low, `result` is `(sri + snd) mod 256` and `carry_out` is bit 8 of that sum.
- R7: With `cla_en` and `neg_snd` high, `result` is `(sri + ~snd + 1) mod 256` and `carry_out` is bit 8 of that sum, so it is 1 exactly when `sri >= snd` (unsigned).
- R8: With only `in_en` high, `result` equals `in_val`.
- R9: With only `npc_en` high, `result` equals `npc_val`.
- R10: With `rop_en`, `cla_en`, `in_en` and `npc_en` all low, `result` is 0 and `zero` is 1, whatever the operands and steering lines hold.
- R11: `carry_out` is 0 whenever `cla_en` is low.
- R12: `zero` is 1 exactly when all eight `result` bits are 0.
- R13: When several source enables are high, `result` is the bitwise OR of the enabled sources. For example, IN together with the boolean unit gives `in_val | (sri | snd)`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sri | input | 8 | Source operand |
| snd | input | 8 | Second operand |
| in_val | input | 8 | External input byte |
| npc_val | input | 8 | Next program counter value |
| neg_snd | input | 1 | Complement the second operand and set the adder carry-in |
| pass_snd | input | 1 | Force the source operand to zero in the boolean unit |
| and_sel | input | 1 | Boolean unit: AND term enable |
| xor_sel | input | 1 | Boolean unit: XOR term enable |
| or_sel | input | 1 | Boolean unit: OR term enable |
| rop_en | input | 1 | Boolean unit result enable |
| cla_en | input | 1 | Adder result and carry enable |
| in_en | input | 1 | External input enable |
| npc_en | input | 1 | Next program counter enable |
| result | output | 8 | Merged result |
| carry_out | output | 1 | Adder carry out, gated by `cla_en` |
| zero | output | 1 | High when `result` is all zeros |

## Verification
Every output is combinational, so each result, carry and zero flag is due in the same cycle that its operands and enables are applied, with no register on the way. The driver changes inputs just after a rising edge and queues the expected triple. The monitor pops and compares one triple at the following falling edge, so the logic has half a period to settle and the comparison never races the stimulus. The expected values come from plain integer arithmetic and bitwise operators on the operands, using the rules stated in the requirements.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  // Order of the result sources on the merge bus
  typedef enum int unsigned {
    SRC_ROP = 0,
    SRC_CLA = 1,
    SRC_IN  = 2,
    SRC_NPC = 3
  } src_idx_e;

  localparam int unsigned SRC_N = 4;
endpackage

// File: rtl/alu8_rop_unit.sv
module alu8_rop_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] sri,
  input  logic [W-1:0] snd,
  input  logic         neg_snd,
  input  logic         pass_snd,
  input  logic         and_sel,
  input  logic         xor_sel,
  input  logic         or_sel,
  output logic [W-1:0] snd_cond,
  output logic [W-1:0] rop_out
);
  logic [W-1:0] a_op;
  logic [W-1:0] t_and, t_xor, t_or;

  // shared complement stage, also feeds the adder
  assign snd_cond = snd ^ {W{neg_snd}};
  assign a_op     = sri & {W{~pass_snd}};

  assign t_and = (a_op & snd_cond) & {W{and_sel}};
  assign t_xor = (a_op ^ snd_cond) & {W{xor_sel}};
  assign t_or  = (a_op | snd_cond) & {W{or_sel}};
  assign rop_out = t_and | t_xor | t_or;

  always_comb begin
    // R5
    if (pass_snd && or_sel && !and_sel && !xor_sel && !neg_snd)
      pass_through_chk: assert (rop_out == snd)
        else $error("pass path does not deliver snd");
  end
endmodule

// File: rtl/alu8_cla.sv
module alu8_cla #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] g, p;
  logic [W:0]   c;

  assign g = a & b;
  assign p = a ^ b;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_carry
    logic cnext;
    always_comb begin
      logic acc, prop;
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prop = 1'b1;
        for (int k = j + 1; k <= i; k++) prop = prop & p[k];
        acc = acc | (g[j] & prop);
      end
      cnext = acc | ((&p[i:0]) & cin);
    end
    assign c[i+1] = cnext;
  end

  assign sum  = p ^ c[W-1:0];
  assign cout = c[W];

  always_comb begin
    // R6 R7
    cla_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("lookahead sum mismatch");
  end
endmodule

// File: rtl/alu8_merge.sv
module alu8_merge
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [SRC_N-1:0][W-1:0] src,
  input  logic [SRC_N-1:0]        en,
  output logic [W-1:0]            merged,
  output logic                    zero
);
  logic [SRC_N-1:0][W-1:0] gated;

  for (genvar s = 0; s < SRC_N; s++) begin : g_gate
    assign gated[s] = src[s] & {W{en[s]}};
  end

  always_comb begin
    merged = '0;
    for (int s = 0; s < SRC_N; s++) merged = merged | gated[s];
  end

  assign zero = ~|merged;

  always_comb begin
    // R10
    if (en == '0)
      clear_zero_chk: assert (merged == '0 && zero)
        else $error("clear does not force zero");
  end

  always_comb begin
    logic [W-1:0] pick;
    pick = '0;
    for (int s = 0; s < SRC_N; s++) if (en[s]) pick = src[s];
    // R8 R9
    if ($onehot(en))
      single_src_chk: assert (merged == pick)
        else $error("single source not forwarded");
  end
endmodule

// File: rtl/alu8_rop_datapath.sv
module alu8_rop_datapath
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] sri,
  input  logic [W-1:0] snd,
  input  logic [W-1:0] in_val,
  input  logic [W-1:0] npc_val,
  input  logic         neg_snd,
  input  logic         pass_snd,
  input  logic         and_sel,
  input  logic         xor_sel,
  input  logic         or_sel,
  input  logic         rop_en,
  input  logic         cla_en,
  input  logic         in_en,
  input  logic         npc_en,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero
);
  logic [W-1:0] snd_cond, rop_out, sum;
  logic         cout;
  logic [SRC_N-1:0][W-1:0] src;
  logic [SRC_N-1:0]        en;

  alu8_rop_unit #(.W(W)) u_rop (
    .sri(sri), .snd(snd), .neg_snd(neg_snd), .pass_snd(pass_snd),
    .and_sel(and_sel), .xor_sel(xor_sel), .or_sel(or_sel),
    .snd_cond(snd_cond), .rop_out(rop_out)
  );

  alu8_cla #(.W(W)) u_cla (
    .a(sri), .b(snd_cond), .cin(neg_snd), .sum(sum), .cout(cout)
  );

  assign src[SRC_ROP] = rop_out;
  assign src[SRC_CLA] = sum;
  assign src[SRC_IN]  = in_val;
  assign src[SRC_NPC] = npc_val;
  assign en[SRC_ROP]  = rop_en;
  assign en[SRC_CLA]  = cla_en;
  assign en[SRC_IN]   = in_en;
  assign en[SRC_NPC]  = npc_en;

  alu8_merge #(.W(W)) u_merge (
    .src(src), .en(en), .merged(result), .zero(zero)
  );

  assign carry_out = cout & cla_en;

  always_comb begin
    // R6
    if (cla_en && !neg_snd && !rop_en && !in_en && !npc_en)
      add_result_chk: assert ({carry_out, result} == ({1'b0, sri} + {1'b0, snd}))
        else $error("add result mismatch at top");
  end
endmodule

// File: tb/sim_alu8_rop_datapath.sv
module sim_alu8_rop_datapath;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] sri, snd, in_val, npc_val;
  logic neg_snd, pass_snd, and_sel, xor_sel, or_sel, rop_en, cla_en, in_en, npc_en;
  logic [7:0] result;
  logic carry_out, zero;

  alu8_rop_datapath u0 (
    .sri(sri), .snd(snd), .in_val(in_val), .npc_val(npc_val),
    .neg_snd(neg_snd), .pass_snd(pass_snd), .and_sel(and_sel),
    .xor_sel(xor_sel), .or_sel(or_sel), .rop_en(rop_en), .cla_en(cla_en),
    .in_en(in_en), .npc_en(npc_en), .result(result),
    .carry_out(carry_out), .zero(zero)
  );

  typedef struct {
    string      tag;
    logic [7:0] res;
    logic       cy;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // control bits: {neg, pass, and, xor, or, rop, cla, in, npc}
  localparam logic [8:0] C_OR   = 9'b0_0_0_0_1_1_0_0_0;
  localparam logic [8:0] C_XOR  = 9'b0_0_0_1_0_1_0_0_0;
  localparam logic [8:0] C_AND  = 9'b0_0_1_0_0_1_0_0_0;
  localparam logic [8:0] C_ANDN = 9'b1_0_1_0_0_1_0_0_0;
  localparam logic [8:0] C_PASS = 9'b0_1_0_0_1_1_0_0_0;
  localparam logic [8:0] C_ADD  = 9'b0_0_0_0_0_0_1_0_0;
  localparam logic [8:0] C_SUB  = 9'b1_0_0_0_0_0_1_0_0;
  localparam logic [8:0] C_IN   = 9'b0_0_0_0_0_0_0_1_0;
  localparam logic [8:0] C_NPC  = 9'b0_0_0_0_0_0_0_0_1;

  task automatic drive(input string tag, input logic [8:0] ctl,
                       input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] iv, input logic [7:0] nv,
                       input logic [7:0] eres, input logic ecy);
    exp_t e;
    @(posedge clk);
    #1;
    {neg_snd, pass_snd, and_sel, xor_sel, or_sel, rop_en, cla_en, in_en, npc_en} = ctl;
    sri = a; snd = b; in_val = iv; npc_val = nv;
    e.tag = tag; e.res = eres; e.cy = ecy;
    q.push_back(e);
  endtask

  task automatic do_add(input string tag, input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    drive(tag, C_ADD, a, b, 8'h5A, 8'hA5, t[7:0], t[8]);
  endtask

  task automatic do_sub(input string tag, input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, ~b} + 9'd1;
    drive(tag, C_SUB, a, b, 8'h5A, 8'hA5, t[7:0], t[8]);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result !== e.res) begin
        errors++;
        $display("FAIL %s result actual %h expected %h", e.tag, result, e.res);
      end
      checks++;
      if (carry_out !== e.cy) begin
        errors++;
        $display("FAIL %s carry actual %b expected %b", e.tag, carry_out, e.cy);
      end
      checks++;
      if (zero !== (e.res == 8'h00)) begin
        errors++;
        $display("FAIL R12 (%s) zero actual %b expected %b", e.tag, zero, (e.res == 8'h00));
      end
    end
  end

  initial begin
    {neg_snd, pass_snd, and_sel, xor_sel, or_sel, rop_en, cla_en, in_en, npc_en} = '0;
    sri = '0; snd = '0; in_val = '0; npc_val = '0;
    // idle state: no source enabled -> clear
    drive("R10 idle", 9'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    drive("R1 or",    C_OR,  8'hC3, 8'h18, 0, 0, 8'hDB, 1'b0);
    drive("R1 or",    C_OR,  8'h00, 8'h00, 0, 0, 8'h00, 1'b0);
    drive("R2 xor",   C_XOR, 8'hF0, 8'h3C, 0, 0, 8'hCC, 1'b0);
    drive("R2 xor",   C_XOR, 8'hA5, 8'hA5, 0, 0, 8'h00, 1'b0);
    drive("R3 and",   C_AND, 8'hF0, 8'h3C, 0, 0, 8'h30, 1'b0);
    drive("R4 andn",  C_ANDN, 8'hF0, 8'h3C, 0, 0, 8'hC0, 1'b0);
    drive("R4 andn",  C_ANDN, 8'hFF, 8'hFF, 0, 0, 8'h00, 1'b0);
    drive("R5 pass",  C_PASS, 8'hFF, 8'h42, 0, 0, 8'h42, 1'b0);
    drive("R5 pass",  C_PASS, 8'h81, 8'h00, 0, 0, 8'h00, 1'b0);
    do_add("R6 add", 8'h12, 8'h34);
    do_add("R6 add carry wrap", 8'hFF, 8'h01);
    do_add("R6 add max", 8'hFF, 8'hFF);
    do_sub("R7 sub", 8'h50, 8'h20);
    do_sub("R7 sub equal", 8'h77, 8'h77);
    do_sub("R7 sub borrow", 8'h00, 8'h01);
    drive("R8 in",    C_IN,  8'hFF, 8'hFF, 8'h9E, 8'h11, 8'h9E, 1'b0);
    drive("R9 npc",   C_NPC, 8'hFF, 8'hFF, 8'h9E, 8'h11, 8'h11, 1'b0);
    // clear with busy steering lines and operands that would carry
    drive("R10 clear", 9'b1_1_1_1_1_0_0_0_0, 8'hFF, 8'h01, 8'hFF, 8'hFF, 8'h00, 1'b0);
    // carry gated: operands that would carry, adder disabled
    drive("R11 no carry", C_OR, 8'hFF, 8'hFF, 0, 0, 8'hFF, 1'b0);
    drive("R11 no carry sub", C_ANDN | 9'b0, 8'h10, 8'h00, 0, 0, 8'h10, 1'b0);
    drive("R13 merge", C_OR | C_IN, 8'h01, 8'h02, 8'h40, 8'h00, 8'h43, 1'b0);
    drive("R13 merge npc", C_IN | C_NPC, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hFF, 1'b0);
    for (int i = 0; i < 16; i++) begin
      do_add("R6 sweep", 8'(i * 37 + 5), 8'(i * 91 + 200));
      do_sub("R7 sweep", 8'(i * 53 + 9), 8'(i * 29 + 3));
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule